// File: doc/BRIEF.md
# Multi-Cycle Handshaked Multiplier Chain

This block is a chain of processing stages. Each stage takes several clock cycles to produce one result, and each one talks to its neighbours through four handshake signals. Every stage is a bit-serial shift-and-add multiplier. It multiplies its operand by a fixed coefficient and consumes one coefficient bit per cycle, so a stage with `COEF_W`-bit coefficients needs `COEF_W` working cycles per sample. With the default coefficients 5 and 3, the two-stage chain returns every sample multiplied by 15, modulo 2^`W`.

A stage's output valid drives the next stage's input valid directly. Readiness travels the other way through a register. Each stage's ready for input reaches its upstream neighbour one cycle late, and so does the sink's `sinkReady`. The source sees the first stage's readiness the same way, one cycle late, as `srcReady`. A stage issues a result only in a cycle where this delayed readiness is high. A stage's ready for input stays high from the moment it goes idle until it takes a sample, so a readiness that has aged by one cycle is still true. A producer must leave at least one idle cycle after each valid, because a consumer's drop in readiness takes one cycle to show up on the delayed path. The stages meet this rule by construction, and the external source must meet it too.

Data on an output is undefined whenever its valid is low. In practice the last result stays on the output until the next one is issued.

Top module: `mcpipe_chain`

## Requirements
- R1: While `rstN` is low, `srcReady` and `outValid` are both low.
- R2: Each result on `outData` equals the sample multiplied by 15, modulo 2^16, for the default coefficients (5 in stage 0, then 3 in stage 1) and `W`=16.
- R3: A stage takes a sample only in a cycle where its ready for input and its input valid are both high. A valid that arrives while the stage is busy is ignored and produces no result.
- R4: `srcReady` is stage 0's ready for input delayed by one register. If a sample is accepted in cycle t, `srcReady` is low in cycle t+2.
- R5: `outValid` is a single-cycle pulse and is never high in two consecutive cycles.
- R6: `outValid` is high in cycle u only if `sinkReady` was high in cycle u-2. One cycle comes from the back-pressure register and one from the output register.
- R7: After a result has been issued, `outData` keeps its value in every cycle where `outValid` is low.
- R8: Results leave in the order in which samples were accepted, and none is lost or duplicated.
- R9: With the chain empty and `sinkReady` held high, a sample accepted in cycle t produces `outValid` in cycle t + 2·`COEF_W` + 4, which is 12 for the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | 1 | Source offers a sample; never high in two consecutive cycles |
| srcData | input | W | Sample from the source |
| srcReady | output | 1 | Stage 0 ready for input, delayed by one cycle |
| outValid | output | 1 | One-cycle pulse marking a result on `outData` |
| outData | output | W | Result of the last stage; undefined while `outValid` is low |
| sinkReady | input | 1 | Sink is able to take a result |

## Verification
The bench builds the chain with its default parameters: two stages, 4-bit coefficients (four working cycles per stage) and a 16-bit datapath. With these values the exact latency of 12 cycles can be checked, and the corner operands 0, 1 and 0xFFFF exercise the modular wrap. The sink stalls at random, first lightly and then heavily, so results pile up in the DONE states of both stages and the back-pressure register is exercised. Extra valids are injected while stage 0 is busy, which shows that these valids are dropped rather than turned into extra results.

// File: rtl/mcpipe_pkg.sv
package mcpipe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } stage_state_e;

  typedef struct packed {
    logic load;
    logic step;
    logic capture;
  } dp_strobe_t;

endpackage

// File: rtl/mcpipe_ctrl.sv
module mcpipe_ctrl
  import mcpipe_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic       rdyOut,
  output logic       outValid,
  output dp_strobe_t strobe
);

  localparam int CW = (STEPS > 2) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

  stage_state_e state;
  logic [CW-1:0] stepCnt;
  logic accept;
  logic issue;

  assign inReady = (state == ST_IDLE);
  assign accept  = inReady && inValid;
  assign issue   = (state == ST_DONE) && rdyOut;

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.step    = (state == ST_BUSY);
    strobe.capture = issue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= issue;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_BUSY;
            stepCnt <= '0;
          end
        end
        ST_BUSY: begin
          if (stepCnt == LAST_STEP) state <= ST_DONE;
          else stepCnt <= stepCnt + 1'b1;
        end
        ST_DONE: begin
          if (issue) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a taken sample makes the stage busy on the next cycle
  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R5: result valid lasts exactly one cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R6: a result is issued only against a delayed ready seen high
  p_issue_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(rdyOut));

endmodule

// File: rtl/mcpipe_dp.sv
module mcpipe_dp
  import mcpipe_pkg::*;
#(
  parameter int W      = 16,
  parameter int COEF_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [W-1:0]      dataIn,
  input  logic [COEF_W-1:0] coef,
  output logic [W-1:0]      dataOut
);

  logic [W-1:0]      acc;
  logic [W-1:0]      mcand;
  logic [COEF_W-1:0] mplier;
  logic [W-1:0]      res;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      res    <= '0;
    end else begin
      if (strobe.load) begin
        acc    <= '0;
        mcand  <= dataIn;
        mplier <= coef;
      end else if (strobe.step) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
      end
      if (strobe.capture) res <= acc;
    end
  end

  assign dataOut = res;

endmodule

// File: rtl/mcpipe_chain.sv
module mcpipe_chain
  import mcpipe_pkg::*;
#(
  parameter int W      = 16,
  parameter int COEF_W = 4,
  parameter int STAGES = 2,
  parameter logic [STAGES*COEF_W-1:0] COEFS = {4'd3, 4'd5}
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         srcValid,
  input  logic [W-1:0] srcData,
  output logic         srcReady,
  output logic         outValid,
  output logic [W-1:0] outData,
  input  logic         sinkReady
);

  logic [STAGES:0]   validBus;
  logic [W-1:0]      dataBus [STAGES+1];
  logic [STAGES-1:0] stageReady;
  logic [STAGES:0]   backReg;

  assign validBus[0] = srcValid;
  assign dataBus[0]  = srcData;

  // one register on every readiness path: bit 0 to the source, bit i+1 to stage i
  always_ff @(posedge clk) begin
    if (!rstN) backReg <= '0;
    else       backReg <= {sinkReady, stageReady};
  end

  assign srcReady = backReg[0];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    dp_strobe_t strobe;

    mcpipe_ctrl #(.STEPS(COEF_W)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .inValid  (validBus[i]),
      .inReady  (stageReady[i]),
      .rdyOut   (backReg[i+1]),
      .outValid (validBus[i+1]),
      .strobe   (strobe)
    );

    mcpipe_dp #(.W(W), .COEF_W(COEF_W)) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .dataIn  (dataBus[i]),
      .coef    (COEFS[i*COEF_W +: COEF_W]),
      .dataOut (dataBus[i+1])
    );
  end

  assign outValid = validBus[STAGES];
  assign outData  = dataBus[STAGES];

  // R4: an accepted sample shows up as low srcReady two cycles later
  p_busy_seen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (srcValid && srcReady) |=> ##1 !srcReady);

  // R6: the chain output waits for sink readiness from two cycles earlier
  p_sink_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sinkReady, 2));

  // R7: output data holds between result pulses
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

endmodule

// File: tb/mcpipe_chain_tb.sv
module mcpipe_chain_tb;

  localparam int W     = 16;
  localparam int STEPS = 4;
  localparam int NS    = 40;
  localparam int LIMIT = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         srcValid;
  logic [W-1:0] srcData;
  logic         srcReady;
  logic         outValid;
  logic [W-1:0] outData;
  logic         sinkReady;

  always #10 clk = ~clk;

  mcpipe_chain u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .srcValid  (srcValid),
    .srcData   (srcData),
    .srcReady  (srcReady),
    .outValid  (outValid),
    .outData   (outData),
    .sinkReady (sinkReady)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [W-1:0] samples [NS];
  logic [W-1:0] expQ[$];
  int           dueLow[$];

  initial begin
    int  cyc;
    int  nextIdx;
    int  lastAccept;
    int  firstAccept;
    int  received;
    bit  lastValid;
    bit  latDone;
    bit  prevOut;
    bit  haveHeld;
    bit  hist1;
    bit  hist2;
    logic [W-1:0] held;

    for (int i = 0; i < NS; i++) begin
      if (i == 0)      samples[i] = 16'h0001;
      else if (i == 1) samples[i] = 16'hFFFF;
      else if (i == 2) samples[i] = 16'h0000;
      else             samples[i] = W'($urandom);
    end

    srcValid = 1'b0; srcData = '0; sinkReady = 1'b0;
    cyc = 0; nextIdx = 0; lastAccept = -100; firstAccept = -1; received = 0;
    lastValid = 0; latDone = 0; prevOut = 0; haveHeld = 0; hist1 = 0; hist2 = 0;
    held = '0;

    repeat (3) @(negedge clk);
    check(srcReady == 1'b0, "R1", "srcReady in reset", srcReady, 0);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    rstN = 1'b1;

    while (!(nextIdx == NS && expQ.size() == 0)) begin
      @(negedge clk);
      cyc++;
      if (cyc > LIMIT) begin
        check(1'b0, "R8", "watchdog expired, results outstanding", expQ.size(), 0);
        break;
      end

      // observe
      if (outValid) begin
        check(hist2 == 1'b1, "R6", "sinkReady two cycles before result", hist2, 1);
        check(prevOut == 1'b0, "R5", "valid in consecutive cycles", prevOut, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected extra result", outData, 0);
        end else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          check(outData == e, "R2/R8", "result value in order", outData, e);
        end
        received++;
        if (!latDone) begin
          check(cyc - firstAccept == 2*STEPS + 4, "R9", "first result latency",
                cyc - firstAccept, 2*STEPS + 4);
          latDone = 1;
        end
        held = outData;
        haveHeld = 1;
      end else if (haveHeld) begin
        check(outData == held, "R7", "output held between pulses", outData, held);
      end
      if (dueLow.size() > 0 && dueLow[0] == cyc) begin
        void'(dueLow.pop_front());
        check(srcReady == 1'b0, "R4", "srcReady low two cycles after accept", srcReady, 0);
      end
      prevOut = outValid;

      // drive
      hist2 = hist1;
      if (received == 0)   sinkReady = 1'b1;
      else if (nextIdx < 20) sinkReady = ($urandom % 4) != 0;
      else                 sinkReady = ($urandom % 4) == 0;
      hist1 = sinkReady;

      srcValid = 1'b0;
      if (srcReady && !lastValid && nextIdx < NS && (received > 0 || nextIdx == 0)) begin
        srcValid = 1'b1;
        srcData  = samples[nextIdx];
        expQ.push_back(W'(samples[nextIdx] * 15));
        if (firstAccept < 0) firstAccept = cyc;
        dueLow.push_back(cyc + 2);
        lastAccept = cyc;
        nextIdx++;
      end else if (!lastValid && cyc == lastAccept + 3 && nextIdx % 3 == 0) begin
        // R3: stage 0 is mid-computation here; this valid must be dropped
        srcValid = 1'b1;
        srcData  = 16'hDEAD;
      end
      lastValid = srcValid;
    end

    @(negedge clk);
    srcValid = 1'b0;
    check(received == NS, "R8", "result count", received, NS);
    check(expQ.size() == 0, "R8", "pending expected results", expQ.size(), 0);
    check(!outValid, "R3", "no result from dropped valids", outValid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule